// File: doc/BRIEF.md
# Eight-Bit Addressable Latch with Decoder Mode

This block holds eight output bits. Software or control logic writes one bit at a time through a 3-bit select and a single data line. An active-low enable and an active-low clear together choose one of four operating modes.

- **Write:** the selected bit is loaded.
- **Hold:** nothing changes.
- **Clear:** all bits are zeroed.
- **Decode:** the selected output carries the data line and every other output is low, so the block acts as a one-of-eight demultiplexer.

The block is a clock-synchronous model of this behaviour. Enable, clear, select and data are sampled on every rising clock edge. All eight outputs come from registers, so every mode takes effect on the output one cycle after it is sampled. A synchronous active-low reset, separate from the functional clear, zeroes the outputs.

Control logic should change the select only while enable is inactive. If the select changes while enable is active, each bit that becomes selected is written on that cycle. Bits selected earlier keep the last value written to them.

Top module: `addr_latch8`

## Requirements
- R1: When `rst_n` is low at a rising edge, all bits of `q` are 0 after that edge.
- R2: The select value k (with `sel[2]` the most significant bit) addresses `q[k]`. After a clear, writing a 1 to select k gives `q` equal to 1 shifted left by k.
- R3: With `en_n`=0 and `clr_n`=1 at an edge, the addressed bit takes the sampled `din` after that edge, and every other bit keeps its value.
- R4: With `en_n`=1 and `clr_n`=1 at an edge, all bits keep their values whatever `din` and `sel` are doing.
- R5: With `en_n`=1 and `clr_n`=0 at an edge, all bits are 0 after that edge.
- R6: With `en_n`=0 and `clr_n`=0 at an edge, the addressed bit equals the sampled `din` and every other bit is 0 after that edge.
- R7: The value sampled on the last cycle with `en_n` low remains in the addressed bit after `en_n` returns high.
- R8: When `sel` changes on consecutive cycles with `en_n` low and `clr_n` high, each newly addressed bit is written on its cycle, and bits written earlier keep their last value.
- R9: `rst_n` low takes priority over every mode, including decode with `din`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset, zeroes all outputs |
| en_n | input | 1 | Active-low enable for write and decode modes |
| clr_n | input | 1 | Active-low functional clear |
| sel | input | 3 | Bit select, value k addresses `q[k]` |
| din | input | 1 | Serial data bit |
| q | output | 8 | Registered latch outputs |

## Verification
The bench checks decode mode on every select with both data values. A design that handled the clear-while-enabled combination like a plain clear would lose the single high output, and one that skipped zeroing the other bits would leave earlier writes visible.

Hold mode is driven with a changing select and data. An implementation that let enable gate only the data, and not the write strobe, would corrupt stored bits during this test.

The bench also changes the select back-to-back while enable stays low. A design that wrote the previously selected bit, or cleared bits it had written before, shows up at once.

Finally, reset is asserted during decode with data high. This catches a reset that loses priority to the mode logic.

// File: rtl/alatch_pkg.sv
// Package: shared types for the addressable latch.
// Assumes: nothing beyond standard SystemVerilog.
package alatch_pkg;

    // Operating mode selected by the enable/clear pair.
    typedef enum logic [1:0] {
        MODE_WRITE  = 2'd0,
        MODE_HOLD   = 2'd1,
        MODE_CLEAR  = 2'd2,
        MODE_DECODE = 2'd3
    } alatch_mode_e;

endpackage

// File: rtl/alatch_mode_dec.sv
// Module: alatch_mode_dec
// Turns the active-low enable and clear levels into one of four modes.
// Assumes: inputs are already synchronous to the block clock.
module alatch_mode_dec
    import alatch_pkg::*;
(
    input  logic         en_n,
    input  logic         clr_n,
    output alatch_mode_e mode
);

    // Map the two control levels onto a mode.
    always_comb begin
        unique case ({en_n, clr_n})
            2'b01:   mode = MODE_WRITE;
            2'b11:   mode = MODE_HOLD;
            2'b10:   mode = MODE_CLEAR;
            default: mode = MODE_DECODE;
        endcase
    end

endmodule

// File: rtl/alatch_sel_dec.sv
// Module: alatch_sel_dec
// Binary select to one-hot hit vector; values past the last bit hit nothing.
// Assumes: SEL_W is wide enough to address NUM_BITS entries.
module alatch_sel_dec #(
    parameter int NUM_BITS = 8,
    parameter int SEL_W    = $clog2(NUM_BITS)
) (
    input  logic [SEL_W-1:0]    sel,
    output logic [NUM_BITS-1:0] hit
);

    // One comparator per output bit.
    for (genvar i = 0; i < NUM_BITS; i++) begin : g_hit
        assign hit[i] = (sel == SEL_W'(i));
    end

endmodule

// File: rtl/alatch_cell.sv
// Module: alatch_cell
// One storage bit: loads, holds, clears or decodes according to the mode.
// Assumes: hit is one-hot across all cells; rst_n is synchronous.
module alatch_cell
    import alatch_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  alatch_mode_e mode,
    input  logic         hit,
    input  logic         din,
    output logic         q
);

    logic q_next;

    // Next-state selection for this bit.
    always_comb begin
        unique case (mode)
            MODE_WRITE:  q_next = hit ? din : q;
            MODE_HOLD:   q_next = q;
            MODE_CLEAR:  q_next = 1'b0;
            MODE_DECODE: q_next = hit & din;
            default:     q_next = q;
        endcase
    end

    // State register with synchronous reset taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= q_next;
    end

endmodule

// File: rtl/addr_latch8.sv
// Module: addr_latch8
// Addressable latch bank with write, hold, clear and decode modes.
// Assumes: a single clock; control inputs synchronous to it; rst_n synchronous.
module addr_latch8
    import alatch_pkg::*;
#(
    parameter  int NUM_BITS = 8,
    localparam int SEL_W    = $clog2(NUM_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_n,
    input  logic                clr_n,
    input  logic [SEL_W-1:0]    sel,
    input  logic                din,
    output logic [NUM_BITS-1:0] q
);

    alatch_mode_e        mode;
    logic [NUM_BITS-1:0] hit;

    alatch_mode_dec u_mode (
        .en_n  (en_n),
        .clr_n (clr_n),
        .mode  (mode)
    );

    alatch_sel_dec #(
        .NUM_BITS (NUM_BITS),
        .SEL_W    (SEL_W)
    ) u_sel (
        .sel (sel),
        .hit (hit)
    );

    // One storage cell per output bit.
    for (genvar i = 0; i < NUM_BITS; i++) begin : g_cell
        alatch_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (mode),
            .hit   (hit[i]),
            .din   (din),
            .q     (q[i])
        );
    end

endmodule

// File: rtl/alatch_chk.sv
// Module: alatch_chk
// Port-level temporal checks for addr_latch8, attached by bind.
// Assumes: the same clock and synchronous reset as the checked block.
module alatch_chk #(
    parameter int NUM_BITS = 8,
    parameter int SEL_W    = $clog2(NUM_BITS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                en_n,
    input logic                clr_n,
    input logic [SEL_W-1:0]    sel,
    input logic                din,
    input logic [NUM_BITS-1:0] q
);

    localparam logic [NUM_BITS-1:0] ONE = NUM_BITS'(1);

    // R1 / R9: reset zeroes the outputs regardless of mode.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (q == '0));

    // R3: addressed bit loads the data.
    a_r3_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && clr_n) |=> (q[$past(sel)] == $past(din)));

    // R3 / R8: unaddressed bits keep their values in write mode.
    a_r3_write_others: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && clr_n) |=> (((q ^ $past(q)) & ~(ONE << $past(sel))) == '0));

    // R4: hold mode keeps every bit.
    a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (en_n && clr_n) |=> $stable(q));

    // R5: clear mode zeroes every bit.
    a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (en_n && !clr_n) |=> (q == '0));

    // R6: decode mode leaves at most the addressed bit high.
    a_r6_decode_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && !clr_n) |=> ($onehot0(q) && (q[$past(sel)] == $past(din))));

endmodule

bind addr_latch8 alatch_chk #(
    .NUM_BITS (NUM_BITS),
    .SEL_W    (SEL_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .en_n  (en_n),
    .clr_n (clr_n),
    .sel   (sel),
    .din   (din),
    .q     (q)
);

// File: tb/sim_addr_latch8.sv
// Directed bench for addr_latch8 with a cycle-level reference model.
module sim_addr_latch8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_n = 1'b1;
    logic       clr_n = 1'b1;
    logic [2:0] sel = '0;
    logic       din = 1'b0;
    logic [7:0] q;
    logic [7:0] model = '0;
    int         n_checks = 0;
    int         n_errors = 0;

    addr_latch8 u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .en_n  (en_n),
        .clr_n (clr_n),
        .sel   (sel),
        .din   (din),
        .q     (q)
    );

    // 125 MHz clock.
    always #4 clk = ~clk;

    // Compare an observed value with an expectation.
    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: q=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle at a falling edge, update the model, and check at the next falling edge.
    task automatic step(input logic e, input logic c, input logic [2:0] s,
                        input logic d, input string req);
        en_n = e; clr_n = c; sel = s; din = d;
        if (!rst_n) model = '0;
        else begin
            case ({e, c})
                2'b01: model[s] = d;
                2'b11: ;
                2'b10: model = '0;
                default: begin model = '0; model[s] = d; end
            endcase
        end
        @(negedge clk);
        check(req, q, model);
    endtask

    // R1: outputs are zero under reset.
    task automatic t_reset;
        rst_n = 1'b0;
        step(1'b1, 1'b1, 3'd0, 1'b0, "R1");
        step(1'b1, 1'b1, 3'd0, 1'b0, "R1");
        check("R1 literal", q, 8'h00);
        rst_n = 1'b1;
    endtask

    // R2: select value k maps to q[k].
    task automatic t_addr_map;
        for (int k = 0; k < 8; k++) begin
            step(1'b1, 1'b0, 3'd0, 1'b0, "R5");
            step(1'b0, 1'b1, 3'(k), 1'b1, "R2");
            check("R2 literal", q, 8'(1 << k));
        end
    endtask

    // R3: write mode loads only the addressed bit.
    task automatic t_write;
        step(1'b1, 1'b0, 3'd0, 1'b0, "R5");
        for (int k = 0; k < 8; k++) begin
            step(1'b0, 1'b1, 3'(k), k[0], "R3");
            step(1'b1, 1'b1, 3'(k), 1'b0, "R3");
        end
        check("R3 literal", q, 8'hAA);
        step(1'b0, 1'b1, 3'd7, 1'b0, "R3");
        check("R3 overwrite", q, 8'h2A);
    endtask

    // R4: hold mode ignores data and select.
    task automatic t_hold;
        for (int k = 0; k < 8; k++) begin
            step(1'b1, 1'b1, 3'(7 - k), ~k[0], "R4");
        end
        check("R4 literal", q, 8'h2A);
    endtask

    // R5: clear mode zeroes all bits.
    task automatic t_clear;
        for (int k = 0; k < 8; k++) step(1'b0, 1'b1, 3'(k), 1'b1, "R3");
        check("R5 setup", q, 8'hFF);
        step(1'b1, 1'b0, 3'd3, 1'b1, "R5");
        check("R5 literal", q, 8'h00);
    endtask

    // R6: decode mode drives one output with the data.
    task automatic t_decode;
        step(1'b0, 1'b1, 3'd2, 1'b1, "R3");
        for (int k = 0; k < 8; k++) begin
            step(1'b0, 1'b0, 3'(k), 1'b1, "R6");
            check("R6 literal", q, 8'(1 << k));
            step(1'b0, 1'b0, 3'(k), 1'b0, "R6");
            check("R6 zero", q, 8'h00);
        end
    endtask

    // R7: value is retained after enable goes high.
    task automatic t_retain;
        step(1'b1, 1'b0, 3'd0, 1'b0, "R5");
        step(1'b0, 1'b1, 3'd5, 1'b0, "R7");
        step(1'b0, 1'b1, 3'd5, 1'b1, "R7");
        step(1'b1, 1'b1, 3'd1, 1'b0, "R7");
        step(1'b1, 1'b1, 3'd5, 1'b0, "R7");
        check("R7 literal", q, 8'h20);
    endtask

    // R8: back-to-back writes while the select moves.
    task automatic t_b2b;
        step(1'b1, 1'b0, 3'd0, 1'b0, "R5");
        step(1'b0, 1'b1, 3'd0, 1'b1, "R8");
        step(1'b0, 1'b1, 3'd3, 1'b1, "R8");
        step(1'b0, 1'b1, 3'd6, 1'b1, "R8");
        step(1'b0, 1'b1, 3'd3, 1'b0, "R8");
        step(1'b0, 1'b1, 3'd7, 1'b1, "R8");
        check("R8 literal", q, 8'hC1);
    endtask

    // R9: reset overrides decode mode.
    task automatic t_reset_prio;
        step(1'b0, 1'b0, 3'd4, 1'b1, "R6");
        rst_n = 1'b0;
        step(1'b0, 1'b0, 3'd4, 1'b1, "R9");
        check("R9 literal", q, 8'h00);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 3'd4, 1'b1, "R9");
        check("R9 release", q, 8'h10);
    endtask

    // Scenario sequence.
    initial begin
        t_reset();
        t_addr_map();
        t_write();
        t_hold();
        t_clear();
        t_decode();
        t_retain();
        t_b2b();
        t_reset_prio();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 100000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: q=%b expected completion", q);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule